// File: doc/BRIEF.md
# Two-Stage Bus Clock Rate Generator

This block produces the timing for a two-wire serial master from the core clock. A baud value holds a linear factor M and an exponent N. The core clock is first divided by a power of two, 2^(N+1), and then by (M+1). The result is a phase tick. Ten ticks make one serial clock period, so the bus rate is core_clk / (10 * (M+1) * 2^(N+1)).

The ten phases are split into a low half (phases 0 to 4) and a high half (phases 5 to 9). A one-cycle drive strobe marks the middle of the low half, where the data line may change. A one-cycle sample strobe marks the middle of the high half, where the data line is read. A slave can stretch the clock: while the high half is being driven but the sensed clock line still reads low, the whole divider chain stops. A soft reset returns the chain to phase 0. The chain runs only while the bus enable input is high.

Top module: `scl_rate_gen`

## Requirements
- R1: A write strobe captures the baud value. M is taken from bits [6:3] (0 to 15) and N from bits [2:0] (0 to 7). The baud value holds its content when no write occurs.
- R2: With the chain running, one phase tick takes T = (M+1) * 2^(N+1) core cycles, and one full serial clock period takes 10*T cycles.
- R3: The clock-high output is low in phases 0 to 4 and high in phases 5 to 9. After a soft reset it rises 5*T cycles later and falls 10*T cycles later, when no stall occurs.
- R4: The drive strobe pulses for exactly one cycle on entry to phase 2. The sample strobe pulses for exactly one cycle on entry to phase 7. The two strobes are never high in the same cycle.
- R5: While the clock-high output is 1 and the sensed clock line is 0, the prescaler, the linear divider and the phase all hold. When the line goes high, counting resumes with no loss, so every later event moves by exactly the stall length.
- R6: While bus enable is low, the prescaler, the divider and the phase all hold, and the outputs keep their values. Later events move by exactly the disabled length.
- R7: A soft reset clears the prescaler, the divider and the phase on the next edge, whether or not the chain is enabled. All three outputs are 0 after that edge.
- R8: A hard reset clears the baud value to 0 (M=0, N=0, T=2) and clears every counter and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst_i | input | 1 | Synchronous restart of the divider chain |
| bus_en_i | input | 1 | Chain runs while high |
| baud_we_i | input | 1 | Baud write strobe |
| baud_wdata_i | input | 7 | Baud value: M in [6:3], N in [2:0] |
| scl_in_i | input | 1 | Sensed clock line level, synchronous to clk |
| scl_hi_o | output | 1 | 1 while the phase is in the high half |
| drv_stb_o | output | 1 | One-cycle strobe on entry to phase 2 |
| smp_stb_o | output | 1 | One-cycle strobe on entry to phase 7 |

## Verification
The hardest case to produce is a stretch that begins on the exact cycle the high half starts. The stall must freeze the prescaler in the middle of its count, not only the phase. Otherwise the resumed tick comes early and the error stays hidden in the total period. The bench models the line as the clock-high output ANDed with a slave hold that is already asserted before the period starts. It releases the hold a chosen number of cycles after the rising edge. It then checks that the sample strobe, the falling edge and the next drive strobe each move by exactly that count. The same method, applied to bus enable in the low half, covers the disabled hold.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  localparam int DEF_M_W      = 4;
  localparam int DEF_N_W      = 3;
  localparam int DEF_PH_COUNT = 10;
  localparam int DEF_PH_HIGH  = 5;
  localparam int DEF_PH_DRV   = 2;
  localparam int DEF_PH_SMP   = 7;
endpackage

// File: rtl/scl_prescale.sv
module scl_prescale #(
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_i,
  input  logic           run_i,
  input  logic [N_W-1:0] n_i,
  output logic           pre_pulse_o
);
  localparam int PW = 1 << N_W;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  // terminal count is 2^(N+1)-1; wraps correctly for N at its maximum
  always_comb lim = (PW'(1) << (int'(n_i) + 1)) - PW'(1);

  assign pre_pulse_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr_i)   cnt_q <= '0;
    else if (run_i)     cnt_q <= pre_pulse_o ? '0 : cnt_q + PW'(1);
  end

  AST_PRE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/scl_lin_div.sv
module scl_lin_div #(
  parameter int M_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_i,
  input  logic           step_i,
  input  logic [M_W-1:0] m_i,
  output logic           tick_o
);
  logic [M_W-1:0] cnt_q;

  assign tick_o = step_i && (cnt_q >= m_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (step_i)   cnt_q <= tick_o ? '0 : cnt_q + M_W'(1);
  end

  AST_DIV_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !clr_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int PH_COUNT = 10,
  parameter int PH_HIGH  = 5,
  parameter int PH_DRV   = 2,
  parameter int PH_SMP   = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic scl_hi_o,
  output logic drv_stb_o,
  output logic smp_stb_o
);
  localparam int PHW = $clog2(PH_COUNT);

  logic [PHW-1:0] ph_q;
  logic [PHW-1:0] ph_nxt;

  always_comb begin
    ph_nxt = ph_q;
    if (tick_i) ph_nxt = (ph_q == PHW'(PH_COUNT-1)) ? '0 : ph_q + PHW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      ph_q      <= '0;
      scl_hi_o  <= 1'b0;
      drv_stb_o <= 1'b0;
      smp_stb_o <= 1'b0;
    end else begin
      ph_q      <= ph_nxt;
      scl_hi_o  <= (ph_nxt >= PHW'(PH_HIGH));
      drv_stb_o <= tick_i && (ph_nxt == PHW'(PH_DRV));
      smp_stb_o <= tick_i && (ph_nxt == PHW'(PH_SMP));
    end
  end

  AST_PH_RANGE: assert property (@(posedge clk) disable iff (rst)
    ph_q < PHW'(PH_COUNT)); // R2
  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(drv_stb_o && smp_stb_o)); // R4
  AST_RISE_HALF: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_hi_o) |-> (ph_q == PHW'(PH_HIGH))); // R3
  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i) |=> $stable(ph_q) && !drv_stb_o && !smp_stb_o); // R5
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int M_W      = scl_rate_pkg::DEF_M_W,
  parameter int N_W      = scl_rate_pkg::DEF_N_W,
  parameter int PH_COUNT = scl_rate_pkg::DEF_PH_COUNT,
  parameter int PH_HIGH  = scl_rate_pkg::DEF_PH_HIGH,
  parameter int PH_DRV   = scl_rate_pkg::DEF_PH_DRV,
  parameter int PH_SMP   = scl_rate_pkg::DEF_PH_SMP
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst_i,
  input  logic               bus_en_i,
  input  logic               baud_we_i,
  input  logic [M_W+N_W-1:0] baud_wdata_i,
  input  logic               scl_in_i,
  output logic               scl_hi_o,
  output logic               drv_stb_o,
  output logic               smp_stb_o
);
  localparam int BAUD_W = M_W + N_W;

  logic [BAUD_W-1:0] baud_q;
  logic [M_W-1:0]    m_val;
  logic [N_W-1:0]    n_val;
  logic              stall;
  logic              run;
  logic              pre_pulse;
  logic              tick;

  always_ff @(posedge clk) begin
    if (rst)            baud_q <= '0;
    else if (baud_we_i) baud_q <= baud_wdata_i;
  end

  assign m_val = baud_q[BAUD_W-1:N_W];
  assign n_val = baud_q[N_W-1:0];

  // a slave holding the line low during the high half freezes the chain
  assign stall = scl_hi_o && !scl_in_i;
  assign run   = bus_en_i && !stall;

  scl_prescale #(.N_W(N_W)) u_pre (
    .clk(clk), .rst(rst), .clr_i(soft_rst_i), .run_i(run),
    .n_i(n_val), .pre_pulse_o(pre_pulse)
  );

  scl_lin_div #(.M_W(M_W)) u_div (
    .clk(clk), .rst(rst), .clr_i(soft_rst_i), .step_i(pre_pulse),
    .m_i(m_val), .tick_o(tick)
  );

  scl_phase_seq #(
    .PH_COUNT(PH_COUNT), .PH_HIGH(PH_HIGH), .PH_DRV(PH_DRV), .PH_SMP(PH_SMP)
  ) u_seq (
    .clk(clk), .rst(rst), .clr_i(soft_rst_i), .run_i(run), .tick_i(tick),
    .scl_hi_o(scl_hi_o), .drv_stb_o(drv_stb_o), .smp_stb_o(smp_stb_o)
  );

  AST_BAUD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !baud_we_i |=> $stable(baud_q)); // R1
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (scl_hi_o && !scl_in_i && !soft_rst_i) |=> scl_hi_o); // R5
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_rst_i |=> (!scl_hi_o && !drv_stb_o && !smp_stb_o)); // R7
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    !bus_en_i |-> !tick); // R6
endmodule

// File: tb/scl_rate_gen_tb_top.sv
module scl_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst = 1'b0;
  logic       bus_en = 1'b0;
  logic       we = 1'b0;
  logic [6:0] wdata = '0;
  logic       hold = 1'b0;
  logic       scl_hi, drv, smp;
  logic       scl_line;
  int         checks = 0;
  int         fails = 0;
  int         cyc = 0;

  always #5 clk = ~clk;

  // open-drain line: low when the master drives low or the slave holds it
  assign scl_line = scl_hi & ~hold;

  scl_rate_gen dut_i (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst), .bus_en_i(bus_en),
    .baud_we_i(we), .baud_wdata_i(wdata), .scl_in_i(scl_line),
    .scl_hi_o(scl_hi), .drv_stb_o(drv), .smp_stb_o(smp)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_start(input logic [6:0] val);
    @(negedge clk);
    we = 1'b1; wdata = val; soft_rst = 1'b1;
    @(negedge clk);
    we = 1'b0; soft_rst = 1'b0;
  endtask

  // s: stretch cycles at start of high half; d: disabled cycles from 3*T
  task automatic measure(input int m, input int nn, input int s, input int d,
                         input string tag);
    int t;
    int rise = -1, fall = -1, drv1 = -1, drv2 = -1, smpt = -1;
    int nd = 0, ns = 0, nr = 0, nf = 0, both = 0;
    logic prev = 1'b0;
    logic [3:0] mv;
    logic [2:0] nv;
    t  = (m + 1) * (2 << nn);
    mv = m[3:0];
    nv = nn[2:0];
    hold = (s > 0);
    cfg_start({mv, nv});
    for (int n = 1; n <= 12*t + s + d + 1; n++) begin
      @(posedge clk); #1;
      if (n == 1) check(!scl_hi && !drv && !smp, "R7", {29'd0, scl_hi, drv, smp}, 0);
      if (scl_hi && !prev) begin nr++; if (rise < 0) rise = n; end
      if (!scl_hi && prev) begin nf++; if (fall < 0) fall = n; end
      prev = scl_hi;
      if (drv) begin nd++; if (nd == 1) drv1 = n; else drv2 = n; end
      if (smp) begin ns++; smpt = n; end
      if (drv && smp) both++;
      if (d > 0 && n == 3*t)     bus_en = 1'b0;
      if (d > 0 && n == 3*t + d) bus_en = 1'b1;
      if (s > 0 && n == 5*t + d + s) hold = 1'b0;
    end
    check(drv1 == 2*t, "R1", drv1, 2*t);             // R1 field decode sets T
    check(rise == 5*t + d, "R3", rise, 5*t + d);
    check(smpt == 7*t + s + d, tag, smpt, 7*t + s + d);
    check(fall == 10*t + s + d, tag, fall, 10*t + s + d);
    check(drv2 == 12*t + s + d, tag, drv2, 12*t + s + d);
    check(nd == 2 && ns == 1, "R4", nd*10 + ns, 21);
    check(nr == 1 && nf == 1, "R3", nr*10 + nf, 11);
    check(both == 0, "R4", both, 0);
    hold = 1'b0;
    bus_en = 1'b1;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!scl_hi && !drv && !smp, "R8", {29'd0, scl_hi, drv, smp}, 0);
    repeat (5) @(negedge clk);
    check(!scl_hi && !drv && !smp, "R6", {29'd0, scl_hi, drv, smp}, 0);
    // R8: baud after reset is zero, so T=2 and first drive strobe at 2*T
    bus_en = 1'b1;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!drv && n < 100);
    check(n == 4, "R8", n, 4);

    // R2: sweep exponent with M=0, then linear factor with N=0
    for (int k = 0; k < 8; k++) measure(0, k, 0, 0, "R2");
    for (int k = 0; k < 16; k++) measure(k, 0, 0, 0, "R2");
    measure(15, 3, 0, 0, "R2");
    measure(5, 2, 0, 0, "R2");
    // R5: slave stretch of several lengths
    measure(1, 0, 7, 0, "R5");
    measure(0, 0, 1, 0, "R5");
    measure(2, 1, 13, 0, "R5");
    // R6: bus enable dropped in the low half
    measure(0, 1, 0, 9, "R6");
    measure(3, 0, 0, 1, "R6");
    // R7: soft reset in the middle of a period, same settings
    measure(1, 1, 0, 0, "R7");
    repeat (37) @(negedge clk);
    measure(1, 1, 0, 0, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule